// File: doc/BRIEF.md
# Frame-Synchronous Byte Descrambler

This block removes the frame-synchronous scrambling from a byte-aligned SONET/SDH receive stream. The keystream comes from a seven-stage generator with polynomial 1 + x^6 + x^7, which repeats every 127 bits. The block advances it eight bits per clock and XORs it onto each payload byte. The most significant bit of a byte meets the earliest keystream bit.

An upstream framer or external frame counter delivers aligned bytes with a valid strobe. It also raises a frame-start marker on the first byte of row 1. The block counts the valid bytes that follow. The first-row overhead bytes (9 columns times the STS/STM order) pass through untouched. The generator is loaded with all ones on the byte right after that overhead. From there it runs freely, one byte step per valid cycle, until the next frame start.

Every output byte leaves exactly one clock after it enters, whether or not it was descrambled. A test input turns off the XOR without disturbing the keystream phase.

Top module: `sonet_byte_descrambler`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `out_data` keeps its previous value.
- R2: A payload byte leaves as the input XOR a key byte. The key byte's bit 7 is the first of eight successive generator outputs, and bit 0 is the last. The generator output obeys y[n] = y[n-7] XOR y[n-6], and the first seven outputs after a load are ones, so the sequence period is 127.
- R3: The valid byte that carries `in_frame_start`, and the valid bytes after it up to OH_BYTES = 9*STS_N in total, leave unchanged.
- R4: The generator is loaded with all ones at valid byte OH_BYTES+1 after a frame start. The key for that byte is 8'hFE, so a zero input byte leaves as 8'hFE.
- R5: The keystream advances only on cycles with `in_valid` high. Idle gaps do not shift it.
- R6: While `dscr_off` is high, every valid byte leaves unchanged. The keystream still advances, so clearing `dscr_off` later in the frame resumes in phase.
- R7: After reset and before the first accepted frame start, every valid byte leaves unchanged.
- R8: `in_frame_start` has no effect on a cycle with `in_valid` low.
- R9: A frame start accepted at any point, including inside the overhead, restarts the overhead count from that byte.
- R10: During and just after reset, `out_valid` is 0 and `out_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Aligned received byte, bit 7 first on the line |
| in_frame_start | input | 1 | Marks the first byte of row 1, qualified by in_valid |
| dscr_off | input | 1 | High: pass data unchanged (test) |
| out_valid | output | 1 | Output byte strobe, one clock after in_valid |
| out_data | output | 8 | Descrambled or passed byte |

## Verification
The bench builds the block with STS_N = 1, so the overhead is 9 bytes. This keeps many frame starts, overhead runs and generator loads within a short run. The payload runs are longer than 16 bytes, so the 127-bit period wraps several times across idle gaps and across toggles of the disable input. Frame starts are placed inside the overhead, inside the payload and on idle cycles. These placements reach the restart and ignore cases of the position counter.

// File: rtl/dscr_pkg.sv
`timescale 1ns/1ps
package dscr_pkg;

    localparam int LFSR_W = 7;
    localparam int BYTE_W = 8;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam lfsr_t LFSR_SEED = '1;

    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,
        PH_OVH  = 2'd1,
        PH_PAY  = 2'd2
    } phase_e;

    typedef struct packed {
        lfsr_t next;
        byte_t key;
    } step_t;

    // Eight serial steps of the generator; stage 7 is bit 6, stage 1 is bit 0.
    // The first step's output lands in key bit 7.
    function automatic step_t lfsr_byte(input lfsr_t s);
        step_t r;
        lfsr_t t;
        t = s;
        r.key = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            r.key[BYTE_W-1-i] = t[LFSR_W-1];
            t = {t[LFSR_W-2:0], t[LFSR_W-1] ^ t[LFSR_W-2]};
        end
        r.next = t;
        return r;
    endfunction

endpackage

// File: rtl/dscr_frame_pos.sv
`timescale 1ns/1ps
module dscr_frame_pos
    import dscr_pkg::*;
#(
    parameter int OH_BYTES = 27
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   valid_i,
    input  logic   frame_start_i,
    output phase_e phase_o,
    output logic   seed_o
);
    localparam int CW = $clog2(OH_BYTES + 1);
    localparam logic [CW-1:0] OH_LAST = CW'(OH_BYTES);

    typedef struct packed {
        phase_e        phase;
        logic          first;
        logic [CW-1:0] cnt;
    } pos_t;

    pos_t pos_d, pos_q;
    logic fs_take;

    always_comb begin
        pos_d   = pos_q;
        fs_take = valid_i && frame_start_i;
        phase_o = fs_take ? PH_OVH : pos_q.phase;
        seed_o  = valid_i && !frame_start_i && (pos_q.phase == PH_PAY) && pos_q.first;

        if (valid_i) begin
            if (frame_start_i) begin
                pos_d.cnt = CW'(1);
                if (OH_LAST <= CW'(1)) begin
                    pos_d.phase = PH_PAY;
                    pos_d.first = 1'b1;
                end else begin
                    pos_d.phase = PH_OVH;
                    pos_d.first = 1'b0;
                end
            end else begin
                case (pos_q.phase)
                    PH_OVH: begin
                        pos_d.cnt = pos_q.cnt + CW'(1);
                        if (pos_q.cnt + CW'(1) == OH_LAST) begin
                            pos_d.phase = PH_PAY;
                            pos_d.first = 1'b1;
                        end
                    end
                    PH_PAY:  pos_d.first = 1'b0;
                    default: pos_d = pos_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '{phase: PH_HUNT, first: 1'b0, cnt: '0};
        end else begin
            pos_q <= pos_d;
        end
    end

    // R3: the overhead count never passes the overhead width
    assert_ovh_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.phase == PH_OVH) |-> (pos_q.cnt < OH_LAST));

    // R8: nothing moves on an idle cycle, frame start or not
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pos_q));

    // R4: a load point is followed by plain payload, never a second load
    assert_single_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_o |=> !pos_q.first);

endmodule

// File: rtl/dscr_keygen.sv
`timescale 1ns/1ps
module dscr_keygen
    import dscr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  logic  seed_i,
    output byte_t key_o
);
    typedef struct packed {
        lfsr_t st;
    } kg_t;

    kg_t   kg_d, kg_q;
    step_t step;

    always_comb begin
        kg_d  = kg_q;
        step  = lfsr_byte(seed_i ? LFSR_SEED : kg_q.st);
        key_o = step.key;
        if (adv_i) begin
            kg_d.st = step.next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kg_q <= '{st: LFSR_SEED};
        end else begin
            kg_q <= kg_d;
        end
    end

    // R5: generator holds across idle cycles
    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(kg_q.st));

    // R2: a maximal-length generator never reaches the all-zero state
    assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kg_q.st != '0);

endmodule

// File: rtl/sonet_byte_descrambler.sv
`timescale 1ns/1ps
module sonet_byte_descrambler
    import dscr_pkg::*;
#(
    parameter int STS_N   = 3,
    parameter int OH_COLS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_frame_start,
    input  logic       dscr_off,
    output logic       out_valid,
    output logic [7:0] out_data
);
    localparam int OH_BYTES = OH_COLS * STS_N;

    typedef struct packed {
        logic  vld;
        byte_t dat;
    } out_t;

    out_t   out_d, out_q;
    phase_e phase;
    logic   seed;
    byte_t  key;

    dscr_frame_pos #(.OH_BYTES(OH_BYTES)) u_pos (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (in_valid),
        .frame_start_i (in_frame_start),
        .phase_o       (phase),
        .seed_o        (seed)
    );

    dscr_keygen u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (in_valid),
        .seed_i (seed),
        .key_o  (key)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            if ((phase == PH_PAY) && !dscr_off) begin
                out_d.dat = in_data ^ key;
            end else begin
                out_d.dat = in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, dat: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.dat;

    // R1: one-clock strobe delay and data hold
    assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R6: disabled path is transparent
    assert_off_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dscr_off) |=> (out_data == $past(in_data)));

    // R3: the frame-start byte itself is never altered
    assert_fs_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_frame_start) |=> (out_data == $past(in_data)));

    // R4: load byte carries key 8'hFE
    assert_seed_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seed && !dscr_off) |=> (out_data == ($past(in_data) ^ 8'hFE)));

endmodule

// File: tb/sonet_byte_descrambler_tb.sv
`timescale 1ns/1ps
module sonet_byte_descrambler_tb;

    localparam int STS_N = 1;
    localparam int OH    = 9 * STS_N;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_frame_start = 1'b0;
    logic       dscr_off = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    sonet_byte_descrambler #(.STS_N(STS_N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_frame_start (in_frame_start),
        .dscr_off       (dscr_off),
        .out_valid      (out_valid),
        .out_data       (out_data)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    seq [0:126];
    int    pos    = 0;
    bit    framed = 0;
    int    idx    = 0;
    bit    exp_v  = 0;
    logic [7:0] exp_d = '0;
    string exp_tag = "R10";
    string exp_ctx = "reset";

    function automatic void build_seq();
        for (int n = 0; n < 127; n++) begin
            seq[n] = (n < 7) ? 1'b1 : (seq[n-7] ^ seq[n-6]);
        end
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || out_data !== exp_d) begin
            fails++;
            $display("FAIL %s (%s): out_valid=%0b out_data=%02h expected out_valid=%0b out_data=%02h",
                     exp_tag, exp_ctx, out_valid, out_data, exp_v, exp_d);
        end
    endtask

    task automatic step(input bit v, input bit fs, input logic [7:0] d,
                        input bit off, input string ctx);
        logic [7:0] key;
        bit pay;
        @(negedge clk);
        compare();
        in_valid = v; in_frame_start = fs; in_data = d; dscr_off = off;
        exp_ctx = ctx;
        exp_v = v;
        if (!v) begin
            exp_tag = "R1";
        end else begin
            if (fs) begin framed = 1; pos = 1; end
            else if (framed && pos < OH + 2) pos++;
            pay = framed && (pos > OH);
            if (pay && pos == OH + 1) idx = 0;
            key = '0;
            if (pay) begin
                for (int b = 0; b < 8; b++) key[7-b] = seq[(idx + b) % 127];
                idx = (idx + 8) % 127;
            end
            exp_d = (pay && !off) ? (d ^ key) : d;
            if (off)                 exp_tag = "R6";
            else if (!framed)        exp_tag = "R7";
            else if (!pay)           exp_tag = "R3";
            else if (pos == OH + 1)  exp_tag = "R4";
            else                     exp_tag = "R2";
        end
    endtask

    task automatic payload(input int n, input int gap_pct, input string ctx);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap_pct) step(0, 0, 8'($urandom), 0, ctx);
            step(1, 0, 8'($urandom), 0, ctx);
        end
    endtask

    task automatic overhead(input int n, input string ctx);
        step(1, 1, 8'hF6, 0, ctx);
        for (int i = 1; i < n; i++) step(1, 0, 8'($urandom), 0, ctx);
    endtask

    initial begin
        build_seq();
        repeat (4) @(negedge clk);
        // R10: first compare sees the reset state
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) step(1, 0, 8'($urandom), 0, "R7 before any frame");
        step(0, 1, 8'hAA, 0, "R8 idle frame start");
        for (int i = 0; i < 4; i++) step(1, 0, 8'($urandom), 0, "R8 still unframed");

        // R4: zero byte at the load point must read 8'hFE
        overhead(OH, "frame 1");
        step(1, 0, 8'h00, 0, "R4 first key byte");
        payload(300, 25, "R5 gaps in payload");

        // R6: disable mid-payload, then resume in phase
        for (int i = 0; i < 40; i++) step(1, 0, 8'($urandom), 1, "R6 disabled");
        payload(60, 10, "R6 resumed");

        // R9: restart inside overhead
        overhead(4, "R9 partial overhead");
        overhead(OH, "R9 restarted overhead");
        step(1, 0, 8'h00, 0, "R9 load after restart");
        payload(50, 20, "R9 payload");

        // R9: restart mid-payload, several short frames with gaps
        for (int f = 0; f < 4; f++) begin
            overhead(OH, "R9 frame loop");
            payload(120, 15, "R2 frame loop");
        end

        step(0, 0, 8'h00, 0, "R1 drain");
        step(0, 0, 8'h00, 0, "R1 drain");
        @(negedge clk);
        compare();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule